// File: doc/BRIEF.md
# Single-Line Configurable Interrupt Controller

This block watches one asynchronous interrupt pin and turns qualifying activity on it into a single interrupt request toward a processor. Software chooses how the pin is sensed: either as a level, low or high, or as an edge, falling or rising. A detected event latches into a sticky pending flag that stays set until software acknowledges it. An enable bit then decides whether the pending flag reaches the interrupt output.

Software reaches the block through a plain 32-bit register port with an address, a write strobe, write data and combinational read data. Every write completes in the cycle it is presented, so the port has no back-pressure and no handshake. Three register layouts exist, and a build-time parameter picks one of them so that the same block can sit behind drivers that expect different offsets. A handler that reads a pending value of zero knows the interrupt was spurious.

Top module: `irq_line_ctrl`

## Requirements
- R1: The control register's bits [1:0] select the sensing mode: 0 = pin low is active (level), 1 = high-to-low transition (edge), 2 = pin high is active (level), 3 = low-to-high transition (edge). Writing a mode and reading it back returns the same value.
- R2: In the two edge modes the pending flag sets only on the selected transition of the synchronized pin. The opposite transition leaves the flag clear.
- R3: In the two level modes the pending flag sets whenever the synchronized pin is at the active level. An acknowledge while that level is still present leaves the flag set.
- R4: Bit 0 of the pending register reads the sticky flag. Writing 1 to that bit clears the flag. Writing 0 has no effect.
- R5: If an event and an acknowledge fall in the same cycle, the flag is set after that cycle.
- R6: Bit 0 of the enable register gates the output: irq_out is high exactly when the pending flag and the enable bit are both 1.
- R7: LAYOUT selects the offsets as follows. LAYOUT 0: control 0x00, pending 0x04, enable 0x08. LAYOUT 1: control 0x00, pending 0x04, enable 0x34. LAYOUT 2: control 0x0C, pending 0x10, enable 0x40.
- R8: After reset the control, enable and pending registers all read 0, and irq_out is 0.
- R9: Register bits above the defined fields read 0. Any other address reads 0, and a write to it changes nothing.
- R10: The pin passes through a two-flop synchronizer. If a pin change is stable before rising edge 1, the pending flag shows it after rising edge 3 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_wr_en | input | 1 | Write strobe, one write per cycle |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Read data for bus_addr, combinational |
| irq_pin | input | 1 | Asynchronous external interrupt pin |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume two things about the inputs: the pin is truly asynchronous, so only its synchronized copy matters, and the bus presents a steady address and write strobe around each rising edge. The bench changes every input on the falling clock edge. It holds each pin level for several cycles so the synchronizer settles before the next check. One sequence deliberately places an acknowledge write in the exact cycle in which a rising edge is detected. All three layouts run side by side under identical stimulus.

// File: rtl/irq_line_pkg.sv
package irq_line_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LOW  = 2'd0,
    TRIG_EDG_FALL = 2'd1,
    TRIG_LVL_HIGH = 2'd2,
    TRIG_EDG_RISE = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PEND = 2'd1,
    SEL_EN   = 2'd2
  } reg_sel_e;

  localparam int unsigned NUM_LAYOUTS = 3;

  // Byte offset of a register in a given layout.
  function automatic logic [11:0] reg_offset(int unsigned layout, reg_sel_e sel);
    logic [11:0] off;
    if (layout == 2) begin
      case (sel)
        SEL_CTRL: off = 12'h00C;
        SEL_PEND: off = 12'h010;
        default:  off = 12'h040;
      endcase
    end else begin
      case (sel)
        SEL_CTRL: off = 12'h000;
        SEL_PEND: off = 12'h004;
        default:  off = (layout == 1) ? 12'h034 : 12'h008;
      endcase
    end
    return off;
  endfunction

  function automatic logic mode_is_edge(trig_mode_e m);
    return m[0];
  endfunction

  function automatic logic mode_active_high(trig_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/irq_trig_detect.sv
module irq_trig_detect
  import irq_line_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_sync,
  input  trig_mode_e mode,
  output logic       event_o
);
  logic prev_q;
  logic lvl_hit;
  logic rise_seen;
  logic fall_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_sync;
  end

  assign rise_seen = pin_sync & ~prev_q;
  assign fall_seen = ~pin_sync & prev_q;
  assign lvl_hit   = mode_active_high(mode) ? pin_sync : ~pin_sync;

  always_comb begin
    if (mode_is_edge(mode))
      event_o = mode_active_high(mode) ? rise_seen : fall_seen;
    else
      event_o = lvl_hit;
  end
endmodule

// File: rtl/irq_line_regs.sv
module irq_line_regs
  import irq_line_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] PEND_ADDR = '0,
  parameter logic [ADDR_W-1:0] EN_ADDR   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              event_i,
  output trig_mode_e        mode_o,
  output logic              pend_o,
  output logic              en_o,
  output logic              ack_o
);
  localparam int unsigned MODE_W = 2;

  trig_mode_e mode_q;
  logic       pend_q;
  logic       en_q;
  logic       hit_ctrl, hit_pend, hit_en;
  logic       unused_wdata;

  assign hit_ctrl = (addr == CTRL_ADDR);
  assign hit_pend = (addr == PEND_ADDR);
  assign hit_en   = (addr == EN_ADDR);
  assign ack_o    = wr_en & hit_pend & wr_data[0];
  assign unused_wdata = ^wr_data[DATA_W-1:MODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TRIG_LVL_LOW;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      if (hit_ctrl) mode_q <= trig_mode_e'(wr_data[MODE_W-1:0]);
      if (hit_en)   en_q   <= wr_data[0];
    end
  end

  // Event has priority over acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (event_i)  pend_q <= 1'b1;
    else if (ack_o)    pend_q <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    if (hit_ctrl)      rd_data[MODE_W-1:0] = mode_q;
    else if (hit_pend) rd_data[0] = pend_q;
    else if (hit_en)   rd_data[0] = en_q;
  end

  assign mode_o = mode_q;
  assign pend_o = pend_q;
  assign en_o   = en_q;
endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl
  import irq_line_pkg::*;
#(
  parameter int unsigned LAYOUT      = 0,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [31:0]       bus_wr_data,
  output logic [31:0]       bus_rd_data,
  input  logic              irq_pin,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(reg_offset(LAYOUT, SEL_CTRL));
  localparam logic [ADDR_W-1:0] PEND_OFF = ADDR_W'(reg_offset(LAYOUT, SEL_PEND));
  localparam logic [ADDR_W-1:0] EN_OFF   = ADDR_W'(reg_offset(LAYOUT, SEL_EN));

  logic       pin_s;
  logic       evt;
  trig_mode_e mode;
  logic       pend;
  logic       en;
  logic       ack_hit;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_pin),
    .sync_out (pin_s)
  );

  irq_trig_detect u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_sync (pin_s),
    .mode     (mode),
    .event_o  (evt)
  );

  irq_line_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (32),
    .CTRL_ADDR (CTRL_OFF),
    .PEND_ADDR (PEND_OFF),
    .EN_ADDR   (EN_OFF)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .wr_en   (bus_wr_en),
    .wr_data (bus_wr_data),
    .rd_data (bus_rd_data),
    .event_i (evt),
    .mode_o  (mode),
    .pend_o  (pend),
    .en_o    (en),
    .ack_o   (ack_hit)
  );

  assign irq_out = pend & en;
endmodule

// File: rtl/irq_line_ctrl_chk.sv
module irq_line_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] rd_data,
  input logic        irq_out,
  input logic        pend,
  input logic        en,
  input logic        evt,
  input logic        ack
);
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq_out) else $error("mask"); // R6

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> pend) else $error("hold"); // R4

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !evt) |=> !pend) else $error("ack"); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend) else $error("set"); // R5

  AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(evt)) else $error("cause"); // R2

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:2] == 30'd0) else $error("upper"); // R9
endmodule

bind irq_line_ctrl irq_line_ctrl_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_data (bus_rd_data),
  .irq_out (irq_out),
  .pend    (pend),
  .en      (en),
  .evt     (evt),
  .ack     (ack_hit)
);

// File: tb/irq_line_ctrl_tb_top.sv
module irq_line_ctrl_tb_top;
  localparam int NL = 3;
  localparam int R_CTRL = 0, R_PEND = 1, R_EN = 2, R_NONE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [7:0]  addr_a [NL];
  logic [31:0] rd_a [NL];
  logic        irq_a [NL];
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  for (genvar k = 0; k < NL; k++) begin : g_lay
    irq_line_ctrl #(.LAYOUT(k)) dut_i (
      .clk (clk), .rst_n (rst_n), .bus_addr (addr_a[k]), .bus_wr_en (wr_en),
      .bus_wr_data (wdata), .bus_rd_data (rd_a[k]), .irq_pin (pin),
      .irq_out (irq_a[k])
    );
  end

  // Offsets per R7; 0x20 is unmapped in every layout (R9).
  function automatic logic [7:0] offs(int lay, int r);
    case (r)
      R_CTRL:  return (lay == 2) ? 8'h0C : 8'h00;
      R_PEND:  return (lay == 2) ? 8'h10 : 8'h04;
      R_EN:    return (lay == 2) ? 8'h40 : ((lay == 1) ? 8'h34 : 8'h08);
      default: return 8'h20;
    endcase
  endfunction

  task automatic chk(string req, int k, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s layout %0d: got %h expected %h", req, k, act, exp);
    end
  endtask

  task automatic set_addr(int r);
    for (int k = 0; k < NL; k++) addr_a[k] = offs(k, r);
  endtask

  task automatic wr(int r, logic [31:0] v);
    @(negedge clk);
    set_addr(r);
    wdata = v;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(int r, logic [31:0] exp, string req);
    @(negedge clk);
    set_addr(r);
    #1;
    for (int k = 0; k < NL; k++) chk(req, k, rd_a[k], exp);
  endtask

  task automatic irq_chk(logic exp, string req);
    for (int k = 0; k < NL; k++) chk(req, k, {31'd0, irq_a[k]}, {31'd0, exp});
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    set_addr(R_CTRL);
    wait_cyc(3);
    // R8: reset state
    rd_chk(R_CTRL, 0, "R8");
    rd_chk(R_EN, 0, "R8");
    rd_chk(R_PEND, 0, "R8");
    irq_chk(1'b0, "R8");
    @(negedge clk) rst_n = 1'b1;

    for (int m = 0; m < 4; m++) begin
      logic act_lvl;
      logic is_edge;
      act_lvl = (m >= 2);
      is_edge = m[0];
      @(negedge clk) pin = ~act_lvl;
      wait_cyc(4);
      wr(R_CTRL, m);
      wait_cyc(4);
      wr(R_PEND, 1);
      rd_chk(R_PEND, 0, "R1");
      irq_chk(1'b0, "R1");
      rd_chk(R_CTRL, m, "R7");

      // R10: latency through synchronizer
      set_addr(R_PEND);
      @(negedge clk) pin = act_lvl;
      @(negedge clk); #1;
      for (int k = 0; k < NL; k++) chk("R10", k, rd_a[k], 0);
      @(negedge clk); #1;
      for (int k = 0; k < NL; k++) chk("R10", k, rd_a[k], 0);
      @(negedge clk); #1;
      for (int k = 0; k < NL; k++) chk("R10", k, rd_a[k], 1);

      wr(R_PEND, 0);
      rd_chk(R_PEND, 1, "R4");
      irq_chk(1'b0, "R6");
      wr(R_EN, 1);
      rd_chk(R_EN, 1, "R6");
      irq_chk(1'b1, "R6");

      wr(R_PEND, 1);
      rd_chk(R_PEND, is_edge ? 0 : 1, is_edge ? "R2" : "R3");
      irq_chk(!is_edge, is_edge ? "R2" : "R3");

      @(negedge clk) pin = ~act_lvl;
      wait_cyc(4);
      rd_chk(R_PEND, is_edge ? 0 : 1, is_edge ? "R2" : "R3");
      wr(R_PEND, 1);
      rd_chk(R_PEND, 0, "R4");
      irq_chk(1'b0, "R4");
      wr(R_EN, 0);
    end

    // R5: event and acknowledge in the same cycle (rising-edge mode)
    wr(R_CTRL, 3);
    @(negedge clk) pin = 1'b0;
    wait_cyc(4);
    wr(R_PEND, 1);
    rd_chk(R_PEND, 0, "R5");
    @(negedge clk) pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    set_addr(R_PEND);
    wdata = 32'd1;
    wr_en = 1'b1;
    @(negedge clk) wr_en = 1'b0;
    rd_chk(R_PEND, 1, "R5");
    wr(R_PEND, 1);
    rd_chk(R_PEND, 0, "R5");

    // R9: undefined bits and unmapped address
    wr(R_CTRL, 32'hFFFF_FFFD);
    rd_chk(R_CTRL, 1, "R9");
    wr(R_EN, 32'hFFFF_FFFE);
    rd_chk(R_EN, 0, "R9");
    wr(R_NONE, 32'hFFFF_FFFF);
    rd_chk(R_NONE, 0, "R9");
    rd_chk(R_CTRL, 1, "R9");
    rd_chk(R_EN, 0, "R9");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule